// File: doc/BRIEF.md
# Pause Flow-Control Resolver

This block settles which direction, if any, pause flow control runs on an Ethernet link once autonegotiation has finished. It looks at the link duplex, at the two pause bits the link partner advertised (symmetric and asymmetric), and at the locally requested mode. The local request is one of off, transmit-only, receive-only or bidirectional.

A controller raises a one-cycle resolve strobe to make the block take a decision. The block samples its inputs on that strobe and stores the outcome in a register. From the stored mode it drives two MAC enables. One tells the receive path to act on incoming pause frames. The other tells the transmit path that it may generate pause frames. The block also supplies the pause-time and extended-pause values that go into generated pause frames.

The table is deliberately one-sided. A partner that advertises only asymmetric pause leads to receive-only operation, and only when the local side asked for bidirectional pause.

Top module: `fcr_pause_resolver`

## Requirements
- R1: While reset is held low at a clock edge, the stored mode becomes off (code 0), both enables are 0, and both pause fields are 0.
- R2: A resolve on a half-duplex link (`link_full_duplex`=0) yields off, whatever the other inputs are.
- R3: On a full-duplex link where the partner advertises both pause bits, a resolve yields the local request unchanged.
- R4: On a full-duplex link where the partner advertises only symmetric pause, a resolve yields bidirectional (3) if the local request is bidirectional, and off otherwise.
- R5: On a full-duplex link where the partner advertises neither bit, a resolve yields off.
- R6: On a full-duplex link where the partner advertises only asymmetric pause, a resolve yields receive-only (2) if the local request is bidirectional, and off otherwise.
- R7: The modes are encoded as off=0, transmit-only=1, receive-only=2, bidirectional=3. `rx_pause_en` is 1 exactly when the stored mode is 2 or 3. `tx_pause_en` is 1 exactly when the stored mode is 1 or 3.
- R8: While the stored mode is not off, `pause_time` is 0x0040 and `pause_ext` is 0. While the mode is off, both are 0.
- R9: The outputs take the new value in the first cycle after the clock edge that samples the strobe. Without a strobe they hold their value, even while the inputs change.
- R10: When the strobe and reset are both active at the same edge, reset wins and the mode becomes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| resolve | input | 1 | One-cycle strobe that samples the inputs |
| link_full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| lp_sym_pause | input | 1 | Partner advertises symmetric pause |
| lp_asym_pause | input | 1 | Partner advertises asymmetric pause |
| local_mode | input | 2 | Requested mode (0 off, 1 tx-only, 2 rx-only, 3 both) |
| fc_mode | output | 2 | Resolved mode, same encoding |
| rx_pause_en | output | 1 | Act on received pause frames |
| tx_pause_en | output | 1 | Allow generation of pause frames |
| pause_time | output | 16 | Pause-time value for generated frames |
| pause_ext | output | 16 | Extended pause value for generated frames |

## Verification
Two events can land on the same clock edge. One is a resolve strobe together with reset. The other is two strobes in successive cycles, where the register must take each new decision without losing the one before it.

The bench raises the strobe while reset is low and expects the outputs to read off. It also drives back-to-back strobes with different inputs and expects each cycle's outputs to follow its own strobe. Between strobes the bench changes the inputs and checks that the outputs do not move.

// File: rtl/fcr_pkg.sv
// Shared types for the pause flow-control resolver.
package fcr_pkg;
    // Encoded flow-control mode; the code values are visible at the ports.
    typedef enum logic [1:0] {
        FC_OFF     = 2'd0,
        FC_TX_ONLY = 2'd1,
        FC_RX_ONLY = 2'd2,
        FC_BIDIR   = 2'd3
    } fc_mode_e;
endpackage

// File: rtl/fcr_table.sv
// Resolution table: combinational choice of flow-control mode from the
// duplex, the partner's two pause bits and the local request.
// Assumes the inputs are stable whenever the caller samples the output.
module fcr_table
    import fcr_pkg::*;
(
    input  logic     full_duplex,
    input  logic     lp_sym,
    input  logic     lp_asym,
    input  fc_mode_e req,
    output fc_mode_e resolved
);
    // Pick the mode; half duplex always forces off.
    always_comb begin
        resolved = FC_OFF;
        if (full_duplex) begin
            unique case ({lp_sym, lp_asym})
                2'b11:   resolved = req;
                2'b10:   resolved = (req == FC_BIDIR) ? FC_BIDIR   : FC_OFF;
                2'b01:   resolved = (req == FC_BIDIR) ? FC_RX_ONLY : FC_OFF;
                default: resolved = FC_OFF;
            endcase
        end
    end
endmodule

// File: rtl/fcr_state.sv
// Mode register: loads the resolved mode on the strobe, holds it otherwise.
// Assumes a synchronous active-low reset that has priority over load.
module fcr_state
    import fcr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  fc_mode_e d,
    output fc_mode_e q
);
    // Store the mode.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= FC_OFF;
        else if (load) q <= d;
    end

    // R9
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    // R9
    load_takes_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R10
    reset_wins_chk: assert property (@(posedge clk)
        !rst_n |=> (q == FC_OFF));
endmodule

// File: rtl/fcr_fields.sv
// Output decode: the MAC enables and the pause-frame fields, derived from
// the stored mode. Assumes PAUSE_QUANTA fits in QW bits.
module fcr_fields
    import fcr_pkg::*;
#(
    parameter int QW           = 16,
    parameter int PAUSE_QUANTA = 64
) (
    input  fc_mode_e        mode,
    output logic            rx_en,
    output logic            tx_en,
    output logic [QW-1:0]   ptime,
    output logic [QW-1:0]   pext
);
    localparam logic [QW-1:0] ACTIVE_TIME = QW'(PAUSE_QUANTA);

    // Decode the direction enables and the frame fields.
    always_comb begin
        rx_en = (mode == FC_RX_ONLY) || (mode == FC_BIDIR);
        tx_en = (mode == FC_TX_ONLY) || (mode == FC_BIDIR);
        ptime = (mode == FC_OFF) ? '0 : ACTIVE_TIME;
        pext  = '0;
    end
endmodule

// File: rtl/fcr_pause_resolver.sv
// Top of the pause flow-control resolver: samples the link state on the
// resolve strobe, registers the mode and drives the MAC pause controls.
// Assumes resolve is a single-cycle strobe, synchronous to clk.
module fcr_pause_resolver
    import fcr_pkg::*;
#(
    parameter int QW           = 16,
    parameter int PAUSE_QUANTA = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          resolve,
    input  logic          link_full_duplex,
    input  logic          lp_sym_pause,
    input  logic          lp_asym_pause,
    input  logic [1:0]    local_mode,
    output logic [1:0]    fc_mode,
    output logic          rx_pause_en,
    output logic          tx_pause_en,
    output logic [QW-1:0] pause_time,
    output logic [QW-1:0] pause_ext
);
    fc_mode_e next_mode;
    fc_mode_e cur_mode;

    fcr_table u_table (
        .full_duplex (link_full_duplex),
        .lp_sym      (lp_sym_pause),
        .lp_asym     (lp_asym_pause),
        .req         (fc_mode_e'(local_mode)),
        .resolved    (next_mode)
    );

    fcr_state u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (resolve),
        .d     (next_mode),
        .q     (cur_mode)
    );

    fcr_fields #(.QW(QW), .PAUSE_QUANTA(PAUSE_QUANTA)) u_fields (
        .mode  (cur_mode),
        .rx_en (rx_pause_en),
        .tx_en (tx_pause_en),
        .ptime (pause_time),
        .pext  (pause_ext)
    );

    // Drive the encoded mode out.
    always_comb fc_mode = cur_mode;

    // R2
    half_duplex_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve && !link_full_duplex) |=> (fc_mode == 2'd0));

    // R6
    asym_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve && link_full_duplex && !lp_sym_pause && lp_asym_pause)
        |=> (fc_mode == (($past(local_mode) == 2'd3) ? 2'd2 : 2'd0)));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_mode == 2'd0) |-> (!rx_pause_en && !tx_pause_en && pause_time == '0));
endmodule

// File: tb/fcr_pause_resolver_tb.sv
// Scoreboard bench: the driver queues expected modes, the monitor compares.
module fcr_pause_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        resolve = 1'b0;
    logic        fd = 1'b0, sym = 1'b0, asym = 1'b0;
    logic [1:0]  lreq = 2'd0;
    logic [1:0]  fc_mode;
    logic        rx_en, tx_en;
    logic [15:0] ptime, pext;

    int checks = 0, fails = 0, cycles = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] exp_cur = 2'd0;
    logic       strobe_seen = 1'b0, rst_seen = 1'b0;
    string      rst_tag = "R1";

    always #4 clk = ~clk;

    fcr_pause_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .resolve(resolve),
        .link_full_duplex(fd), .lp_sym_pause(sym), .lp_asym_pause(asym),
        .local_mode(lreq), .fc_mode(fc_mode), .rx_pause_en(rx_en),
        .tx_pause_en(tx_en), .pause_time(ptime), .pause_ext(pext)
    );

    // Expected mode from the requirements.
    function automatic logic [1:0] model(logic f, logic s, logic a, logic [1:0] r);
        if (!f) return 2'd0;                       // R2
        if (s && a) return r;                      // R3
        if (s) return (r == 2'd3) ? 2'd3 : 2'd0;   // R4
        if (a) return (r == 2'd3) ? 2'd2 : 2'd0;   // R6
        return 2'd0;                               // R5
    endfunction

    function automatic string rule_tag(logic f, logic s, logic a);
        if (!f) return "R2";
        if (s && a) return "R3";
        if (s) return "R4";
        if (a) return "R6";
        return "R5";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag, logic [1:0] m);
        check(tag, {30'd0, fc_mode}, {30'd0, m});
        check("R7", {30'd0, rx_en, tx_en},
              {30'd0, (m == 2'd2 || m == 2'd3), (m == 2'd1 || m == 2'd3)});
        check("R8", {ptime, pext}, {(m != 2'd0) ? 16'h0040 : 16'h0000, 16'h0000});
    endtask

    // Record what the edge saw.
    always @(posedge clk) begin
        strobe_seen <= resolve && rst_n;
        rst_seen    <= !rst_n;
        cycles      <= cycles + 1;
    end

    // Monitor: compare outputs against the scoreboard each cycle.
    always @(negedge clk) begin
        if (rst_seen) begin
            exp_cur = 2'd0;
            compare_all(rst_tag, exp_cur);
        end else if (strobe_seen) begin
            if (exp_q.size() > 0) begin
                exp_cur = exp_q.pop_front();
                compare_all(tag_q.pop_front(), exp_cur);
            end
        end else begin
            compare_all("R9", exp_cur);
        end
    end

    // Driver: apply inputs with a strobe and queue the expected mode.
    task automatic drive(logic f, logic s, logic a, logic [1:0] r, logic strobe);
        fd = f; sym = s; asym = a; lreq = r; resolve = strobe;
        if (strobe && rst_n) begin
            exp_q.push_back(model(f, s, a, r));
            tag_q.push_back(rule_tag(f, s, a));
        end
        @(negedge clk);
        resolve = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Every input combination, one strobe each, back to back.
        for (int i = 0; i < 32; i++)
            drive(i[4], i[3], i[2], i[1:0], 1'b1);
        // R9: inputs move without a strobe; outputs must hold.
        drive(1'b1, 1'b1, 1'b1, 2'd3, 1'b1);
        for (int i = 0; i < 6; i++)
            drive(i[0], ~i[0], i[1], 2'(i), 1'b0);
        // Spaced strobes.
        drive(1'b1, 1'b1, 1'b1, 2'd1, 1'b1);
        drive(1'b1, 1'b0, 1'b1, 2'd3, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 2'd3, 1'b1);
        // R10: strobe and reset at the same edge.
        rst_tag = "R10";
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 1'b1, 2'd3, 1'b1);
        rst_n = 1'b1;
        rst_tag = "R1";
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 2'd3, 1'b1);
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cycles > 5000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<5000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule